// File: doc/BRIEF.md
# Dual-Source Bootstrap Loader

This block is a hardware sequencer that runs once after reset and places the first program into RAM. It can fetch that program from one of two sources. The first is sector 0 of a CompactFlash card, read through a small task-file register port. The second is a short binary image that arrives over a serial byte stream. When the image is in RAM, the block raises a one-cycle start request and presents the load address. The processor core can then begin executing there.

The source is picked by a race. After reset the sequencer alternates, one cycle each, between offering to take a serial byte and reading the card's status register. A card normally stays busy for about half a second after power-up. If an operator presses a key during that window, serial mode wins. The keypress byte is consumed and thrown away, and the image proper follows it. If the card reports not-busy first, the sequencer loads the sector instead.

In both modes the bytes are written to RAM starting at the load base. Once a mode is chosen, the other source is ignored until the next reset. A watchdog covers the case of a card that never completes the read command.

Top module: `boot_loader`

## Requirements
- R1: While `rst_n` is low, all strobes and flags are low: `ser_ready`, `cf_rd_stb`, `cf_wr_stb`, `ram_own`, `ram_we`, `start_req`, `done` and `err`. The release of reset is synchronised internally, and `ser_ready` first goes high in the third clock cycle after `rst_n` rises.
- R2: Before a mode is chosen, each cycle carries exactly one of two events: either `ser_ready` is high, or a status read is made (`cf_rd_stb` with `cf_reg_sel`=7). These two events alternate from cycle to cycle.
- R3: A serial byte accepted (`ser_valid` and `ser_ready` high at a clock edge) before any status read shows busy clear (status bit 7 = 0) selects serial mode. That byte is never written to RAM.
- R4: In serial mode exactly SER_BYTES further bytes are accepted. Byte k is written to address LOAD_BASE+k with a `ram_we` pulse of one cycle, in the cycle after it was accepted. No other RAM write is made.
- R5: `start_req` is high for exactly one cycle, in the cycle after the last RAM write strobe. `start_addr` equals LOAD_BASE. `done` rises with `start_req` and stays high until reset.
- R6: A status read showing busy clear (bit 7 = 0) before any serial byte is accepted selects card mode. The block then makes six task-file writes, one per cycle, in this order: register 2 = 0x01, register 3 = 0x00, register 4 = 0x00, register 5 = 0x00, register 6 = 0xE0, register 7 = 0x20.
- R7: After the command write, the block reads status (register 7) every cycle until it sees busy (bit 7) = 0 and data request (bit 3) = 1. It then reads register 0 SECTOR_BYTES times in consecutive cycles, and writes byte k to LOAD_BASE+k in the cycle after byte k was read.
- R8: Once a mode is chosen, the other source is ignored. In serial mode no card strobe is issued. In card mode `ser_ready` stays low, so a waiting serial byte is never taken.
- R9: If TIMEOUT_CYC status reads after the command write all fail to see busy clear with data request set, `err` rises in the next cycle and stays high until reset. After that there is no `start_req`, no `done`, no RAM write and no further card strobe.
- R10: `ram_own` is high from the cycle the mode is chosen up to and including the cycle of the last RAM write, and low at every other time. `ram_we` is high only while `ram_own` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_valid | input | 1 | Serial receiver holds a byte |
| ser_data | input | 8 | Serial byte |
| ser_ready | output | 1 | Loader takes the byte at this edge if valid |
| cf_reg_sel | output | 3 | Task-file register index |
| cf_rd_stb | output | 1 | Task-file read strobe |
| cf_wr_stb | output | 1 | Task-file write strobe |
| cf_wdata | output | 8 | Task-file write data |
| cf_rdata | input | 8 | Task-file read data, valid in the cycle of the strobe |
| ram_own | output | 1 | Loader drives the RAM port |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| start_req | output | 1 | One-cycle request to start execution |
| start_addr | output | ADDR_W | Execution start address |
| done | output | 1 | Load finished, held until reset |
| err | output | 1 | Card read timed out, held until reset |

## Verification
The bench keeps LOAD_BASE, SER_BYTES and SECTOR_BYTES at their defaults, so both full image lengths and the exact address ranges are covered. It lowers TIMEOUT_CYC to 40, which makes a card that never finishes its read time out within a short run. That makes R9 reachable and lets the bench count the exact number of status reads before `err` rises. The model card raises busy for 12 cycles after the command, which is well inside that limit.

// File: rtl/bootld_pkg.sv
package bootld_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL_SER,
    ST_POLL_CF,
    ST_SER_LOAD,
    ST_CF_TF,
    ST_CF_WAIT,
    ST_CF_READ,
    ST_FLUSH,
    ST_START,
    ST_DONE,
    ST_ERR
  } ld_state_e;

  localparam logic [2:0] REG_DATA   = 3'd0;
  localparam logic [2:0] REG_STATUS = 3'd7;
  localparam int         STAT_BUSY  = 7;
  localparam int         STAT_DREQ  = 3;
  localparam int         TF_STEPS   = 6;

  function automatic logic [2:0] tf_reg(input logic [2:0] step);
    case (step)
      3'd0:    tf_reg = 3'd2;
      3'd1:    tf_reg = 3'd3;
      3'd2:    tf_reg = 3'd4;
      3'd3:    tf_reg = 3'd5;
      3'd4:    tf_reg = 3'd6;
      default: tf_reg = 3'd7;
    endcase
  endfunction

  function automatic logic [7:0] tf_val(input logic [2:0] step);
    case (step)
      3'd0:    tf_val = 8'h01;
      3'd4:    tf_val = 8'hE0;
      3'd5:    tf_val = 8'h20;
      default: tf_val = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/bootld_rst_sync.sv
module bootld_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/bootld_cnt.sv
module bootld_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] last_val,
  output logic [W-1:0] cnt,
  output logic         at_last
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign at_last = (cnt_q == last_val);

endmodule

// File: rtl/bootld_wdog.sv
module bootld_wdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [W-1:0] tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tick_q <= '0;
    else if (run) tick_q <= tick_q + 1'b1;
    else          tick_q <= '0;
  end

  assign expired = run && (tick_q == W'(LIMIT - 1));

endmodule

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int          ADDR_W       = 16,
  parameter logic [15:0] LOAD_BASE    = 16'hB000,
  parameter int          SER_BYTES    = 256,
  parameter int          SECTOR_BYTES = 512,
  parameter int          TIMEOUT_CYC  = 1000000,
  parameter int          RST_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_valid,
  input  logic [7:0]        ser_data,
  output logic              ser_ready,
  output logic [2:0]        cf_reg_sel,
  output logic              cf_rd_stb,
  output logic              cf_wr_stb,
  output logic [7:0]        cf_wdata,
  input  logic [7:0]        cf_rdata,
  output logic              ram_own,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              start_req,
  output logic [ADDR_W-1:0] start_addr,
  output logic              done,
  output logic              err
);

  import bootld_pkg::*;

  localparam int MAX_BYTES = (SER_BYTES > SECTOR_BYTES) ? SER_BYTES : SECTOR_BYTES;
  localparam int CNT_RAW   = $clog2(MAX_BYTES);
  localparam int CNT_W     = (CNT_RAW < 3) ? 3 : CNT_RAW;

  logic             rst_i_n;
  ld_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt, last_val;
  logic             cnt_last, cnt_inc, cnt_clr;
  logic             wd_run, wd_expired;
  logic             wr_set;
  logic [7:0]       wr_byte;
  logic [ADDR_W-1:0] wr_addr;
  logic             we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]       data_q;

  bootld_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_i_n)
  );

  bootld_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .last_val (last_val),
    .cnt      (cnt),
    .at_last  (cnt_last)
  );

  bootld_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (wd_run),
    .expired (wd_expired)
  );

  always_comb begin
    case (state_q)
      ST_SER_LOAD: last_val = CNT_W'(SER_BYTES - 1);
      ST_CF_TF:    last_val = CNT_W'(TF_STEPS - 1);
      default:     last_val = CNT_W'(SECTOR_BYTES - 1);
    endcase
  end

  // next-state and output decode
  always_comb begin
    state_d    = state_q;
    ser_ready  = 1'b0;
    cf_rd_stb  = 1'b0;
    cf_wr_stb  = 1'b0;
    cf_reg_sel = REG_STATUS;
    cf_wdata   = 8'h00;
    cnt_inc    = 1'b0;
    wr_set     = 1'b0;
    wr_byte    = ser_data;
    case (state_q)
      ST_IDLE: state_d = ST_POLL_SER;
      ST_POLL_SER: begin
        ser_ready = 1'b1;
        state_d   = ser_valid ? ST_SER_LOAD : ST_POLL_CF;
      end
      ST_POLL_CF: begin
        cf_rd_stb = 1'b1;
        state_d   = cf_rdata[STAT_BUSY] ? ST_POLL_SER : ST_CF_TF;
      end
      ST_SER_LOAD: begin
        ser_ready = 1'b1;
        if (ser_valid) begin
          cnt_inc = 1'b1;
          wr_set  = 1'b1;
          if (cnt_last) state_d = ST_FLUSH;
        end
      end
      ST_CF_TF: begin
        cf_wr_stb  = 1'b1;
        cf_reg_sel = tf_reg(cnt[2:0]);
        cf_wdata   = tf_val(cnt[2:0]);
        cnt_inc    = 1'b1;
        if (cnt_last) state_d = ST_CF_WAIT;
      end
      ST_CF_WAIT: begin
        cf_rd_stb = 1'b1;
        if (!cf_rdata[STAT_BUSY] && cf_rdata[STAT_DREQ]) state_d = ST_CF_READ;
        else if (wd_expired)                             state_d = ST_ERR;
      end
      ST_CF_READ: begin
        cf_rd_stb  = 1'b1;
        cf_reg_sel = REG_DATA;
        cnt_inc    = 1'b1;
        wr_set     = 1'b1;
        wr_byte    = cf_rdata;
        if (cnt_last) state_d = ST_FLUSH;
      end
      ST_FLUSH: state_d = ST_START;
      ST_START: state_d = ST_DONE;
      ST_DONE:  state_d = ST_DONE;
      ST_ERR:   state_d = ST_ERR;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign cnt_clr = (state_d != state_q);
  assign wd_run  = (state_q == ST_CF_WAIT);
  assign wr_addr = ADDR_W'(LOAD_BASE) + ADDR_W'(cnt);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  // one-cycle write pipeline
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= wr_set;
      if (wr_set) begin
        addr_q <= wr_addr;
        data_q <= wr_byte;
      end
    end
  end

  assign ram_we     = we_q;
  assign ram_addr   = addr_q;
  assign ram_wdata  = data_q;
  assign ram_own    = (state_q == ST_SER_LOAD) || (state_q == ST_CF_TF) ||
                      (state_q == ST_CF_WAIT)  || (state_q == ST_CF_READ) ||
                      (state_q == ST_FLUSH);
  assign start_req  = (state_q == ST_START);
  assign done       = (state_q == ST_START) || (state_q == ST_DONE);
  assign err        = (state_q == ST_ERR);
  assign start_addr = ADDR_W'(LOAD_BASE);

endmodule

// File: rtl/bootld_chk.sv
module bootld_chk #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] LOAD_BASE = 16'hB000,
  parameter int          SPAN      = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_ready,
  input logic              cf_rd_stb,
  input logic              cf_wr_stb,
  input logic              ram_own,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              start_req,
  input logic              done,
  input logic              err
);

  localparam logic [ADDR_W-1:0] LO = ADDR_W'(LOAD_BASE);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(LOAD_BASE + SPAN);

  p_reset_quiet_r1: assert property (@(negedge clk)
    !rst_n |-> !(ser_ready || cf_rd_stb || cf_wr_stb || ram_own || ram_we ||
                 start_req || done || err));

  p_one_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_ready |-> !(cf_rd_stb || cf_wr_stb));

  p_addr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr >= LO) && (ram_addr < HI));

  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !start_req && done);

  p_done_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_err_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && !start_req && !ram_we && !cf_rd_stb && !cf_wr_stb);

  p_we_owned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_own);

endmodule

bind boot_loader bootld_chk #(
  .ADDR_W    (ADDR_W),
  .LOAD_BASE (LOAD_BASE),
  .SPAN      ((SECTOR_BYTES > SER_BYTES) ? SECTOR_BYTES : SER_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_ready (ser_ready),
  .cf_rd_stb (cf_rd_stb),
  .cf_wr_stb (cf_wr_stb),
  .ram_own   (ram_own),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .start_req (start_req),
  .done      (done),
  .err       (err)
);

// File: tb/boot_loader_test.sv
`timescale 1ns/1ps
module boot_loader_test;

  localparam int ADDR_W = 16;
  localparam int BASE   = 16'hB000;
  localparam int NSER   = 256;
  localparam int NSEC   = 512;
  localparam int TMO    = 40;
  localparam int CMD_DLY = 12;
  localparam int NEVER  = 255;

  // scenario table: {key cycle, busy-clear cycle, expected mode (1 = serial)}
  localparam logic [16:0] SCEN [5] = '{
    {8'd5,   8'd80, 1'b1},
    {8'd255, 8'd10, 1'b0},
    {8'd40,  8'd20, 1'b0},
    {8'd30,  8'd31, 1'b1},
    {8'd31,  8'd30, 1'b0}
  };
  // expected task-file writes: {reg, value}
  localparam logic [10:0] TF_EXP [6] = '{
    {3'd2, 8'h01}, {3'd3, 8'h00}, {3'd4, 8'h00},
    {3'd5, 8'h00}, {3'd6, 8'hE0}, {3'd7, 8'h20}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ser_valid;
  logic [7:0] ser_data;
  logic ser_ready;
  logic [2:0] cf_reg_sel;
  logic cf_rd_stb, cf_wr_stb;
  logic [7:0] cf_wdata, cf_rdata;
  logic ram_own, ram_we;
  logic [ADDR_W-1:0] ram_addr, start_addr;
  logic [7:0] ram_wdata;
  logic start_req, done, err;

  always #2 clk = ~clk;

  boot_loader #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_data(ser_data),
    .ser_ready(ser_ready), .cf_reg_sel(cf_reg_sel), .cf_rd_stb(cf_rd_stb),
    .cf_wr_stb(cf_wr_stb), .cf_wdata(cf_wdata), .cf_rdata(cf_rdata),
    .ram_own(ram_own), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .start_req(start_req), .start_addr(start_addr),
    .done(done), .err(err));

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // card model
  logic boot_busy, hang, cmd_seen;
  int   cmd_cnt, pops, tf_n, stat_after_cmd, cf_own_stb, cf_after_err;
  logic [10:0] tf_log [8];
  int   tf_cyc [8];
  // RAM model
  logic [7:0] mem [NSEC];
  int   wcount, oor, own_viol, starts, ready_own;

  function automatic logic [7:0] cf_pat(input int i);
    cf_pat = 8'((i * 5) + (i >> 8) + 1);
  endfunction
  function automatic logic [7:0] ser_pat(input int i);
    ser_pat = 8'((i ^ 8'h3C) + 7);
  endfunction

  always_comb begin
    case (cf_reg_sel)
      3'd7:    cf_rdata = {boot_busy | (cmd_seen & (cmd_cnt > 0 | hang)), 1'b1, 2'b00,
                           cmd_seen & (cmd_cnt == 0) & !hang & (pops < NSEC), 3'b000};
      3'd0:    cf_rdata = cf_pat(pops);
      default: cf_rdata = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cmd_cnt > 0) cmd_cnt = cmd_cnt - 1;
    if (cf_wr_stb) begin
      if (tf_n < 8) begin tf_log[tf_n] = {cf_reg_sel, cf_wdata}; tf_cyc[tf_n] = cyc; end
      tf_n = tf_n + 1;
      if (cf_reg_sel == 3'd7 && cf_wdata == 8'h20) begin cmd_seen = 1'b1; cmd_cnt = CMD_DLY; end
    end
    if (cf_rd_stb && cf_reg_sel == 3'd0) pops = pops + 1;
    if (cf_rd_stb && cf_reg_sel == 3'd7 && cmd_seen && !err) stat_after_cmd = stat_after_cmd + 1;
    if ((cf_rd_stb || cf_wr_stb) && ram_own && ser_ready) cf_own_stb = cf_own_stb + 1;
    if ((cf_rd_stb || cf_wr_stb) && err) cf_after_err = cf_after_err + 1;
    if (ram_we) begin
      wcount = wcount + 1;
      if (!ram_own) own_viol = own_viol + 1;
      if (ram_addr >= BASE && ram_addr < BASE + NSEC) mem[ram_addr - BASE] = ram_wdata;
      else oor = oor + 1;
    end
    if (start_req) starts = starts + 1;
    if (ser_ready && ram_own && cf_rd_stb) ready_own = ready_own + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ser_valid = 1'b0; ser_data = 8'h00;
    boot_busy = 1'b1; hang = 1'b0; cmd_seen = 1'b0; cmd_cnt = 0; pops = 0;
    tf_n = 0; stat_after_cmd = 0; cf_own_stb = 0; cf_after_err = 0;
    wcount = 0; oor = 0; own_viol = 0; starts = 0; ready_own = 0;
    for (int i = 0; i < NSEC; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [7:0] b);
    ser_data = b; ser_valid = 1'b1;
    while (!ser_ready) @(negedge clk);
    @(negedge clk);
    ser_valid = 1'b0;
  endtask

  task automatic wait_end(output int n);
    n = 0;
    while (!done && !err && n < 5000) begin @(negedge clk); n++; end
  endtask

  int mism, n, first, bad_alt, ready_seen;
  bit key_taken, mode_ser;

  initial begin
    rst_n = 1'b0; ser_valid = 1'b0; ser_data = 8'h00; boot_busy = 1'b1;
    hang = 1'b0; cmd_seen = 1'b0; cmd_cnt = 0; pops = 0; tf_n = 0;

    // ---- R1: reset state and synchronised release
    do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk(!(ser_ready | cf_rd_stb | cf_wr_stb | ram_own | ram_we | start_req | done | err),
        "R1 reset quiet", {ser_ready, cf_rd_stb, cf_wr_stb, ram_own, ram_we, start_req, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk); first = ser_ready;
    @(negedge clk); first = first | ser_ready | cf_rd_stb;
    chk(first == 0, "R1 no poll before third cycle", first, 0);
    @(negedge clk);
    chk(ser_ready == 1'b1, "R1 ser_ready in third cycle", ser_ready, 1);

    // ---- R2: alternation while card busy and no key
    bad_alt = 0;
    for (int i = 0; i < 16; i++) begin
      if ((ser_ready == (cf_rd_stb && cf_reg_sel == 3'd7)) || (i % 2 == 0 && !ser_ready) ||
          (i % 2 == 1 && ser_ready)) bad_alt++;
      @(negedge clk);
    end
    chk(bad_alt == 0, "R2 alternation", bad_alt, 0);

    // ---- scenario table: race outcomes, loads, start timing
    for (int s = 0; s < 5; s++) begin
      do_reset();
      key_taken = 1'b0; ready_seen = 0;
      for (int c = 0; c < 400 && !ram_own; c++) begin
        if (c == int'(SCEN[s][8:1])) boot_busy = 1'b0;
        if (c == int'(SCEN[s][16:9])) begin ser_valid = 1'b1; ser_data = 8'hA5; end
        if (ser_valid && ser_ready) begin @(negedge clk); ser_valid = 1'b0; key_taken = 1'b1; end
        else @(negedge clk);
      end
      mode_ser = ser_ready;
      chk(mode_ser == SCEN[s][0], $sformatf("R3 R6 mode scen%0d", s), mode_ser, SCEN[s][0]);
      if (mode_ser) begin
        boot_busy = 1'b0;
        for (int i = 0; i < NSER; i++) begin
          if (i % 5 == 0) @(negedge clk);
          send(ser_pat(i));
        end
        chk(ram_we && start_req == 1'b0, "R5 no start in write cycle", start_req, 0);
        @(negedge clk);
        chk(start_req && done && start_addr == 16'hB000, "R5 start pulse", {start_req, done}, 3);
        @(negedge clk);
        chk(!start_req && done, "R5 start one cycle", start_req, 0);
        mism = 0;
        for (int i = 0; i < NSER; i++) if (mem[i] != ser_pat(i)) mism++;
        chk(mism == 0 && wcount == NSER, "R3 R4 serial image, key not stored", wcount, NSER);
        chk(tf_n == 0 && cf_own_stb == 0, "R8 card idle in serial mode", tf_n, 0);
      end else begin
        wait_end(n);
        repeat (3) @(negedge clk);
        mism = 0;
        for (int i = 0; i < NSEC; i++) if (mem[i] != cf_pat(i)) mism++;
        chk(mism == 0 && wcount == NSEC && pops == NSEC, "R7 sector image", mism, 0);
        chk(ser_valid == SCEN[s][16:9] != 8'd255 && !key_taken, "R8 key ignored in card mode",
            key_taken, 0);
        chk(starts == 1 && done, "R5 start once", starts, 1);
      end
      chk(oor == 0 && own_viol == 0, "R10 writes owned and in range", oor + own_viol, 0);
      chk(!ram_own, "R10 own low after load", ram_own, 0);
      ser_valid = 1'b0;
      if (s == 1) begin
        // ---- R6: task-file sequence, one per cycle
        mism = 0;
        for (int k = 0; k < 6; k++) begin
          if (tf_log[k] != TF_EXP[k]) mism++;
          if (k > 0 && tf_cyc[k] != tf_cyc[k-1] + 1) mism++;
        end
        chk(mism == 0 && tf_n == 6, "R6 task-file writes", tf_n, 6);
        repeat (20) @(negedge clk);
        chk(done && !err, "R5 done held", done, 1);
      end
    end

    // ---- R9: card never finishes the read
    do_reset();
    hang = 1'b1;
    repeat (5) @(negedge clk);
    boot_busy = 1'b0;
    wait_end(n);
    chk(err && !done, "R9 err raised", {err, done}, 2);
    chk(stat_after_cmd == TMO, "R9 timeout length", stat_after_cmd, TMO);
    repeat (12) @(negedge clk);
    chk(err && starts == 0 && wcount == 0 && cf_after_err == 0 && !ram_own,
        "R9 quiet after err", starts + wcount + cf_after_err, 0);

    // ---- R1: reset mid-load clears everything at once
    do_reset();
    repeat (10) @(negedge clk);
    send(8'h11);
    for (int i = 0; i < 20; i++) send(ser_pat(i));
    #0.5 rst_n = 1'b0;
    #0.5;
    chk(!(ram_own | ram_we | ser_ready), "R1 async reset mid-load", {ram_own, ram_we, ser_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ser_ready && !ram_own, "R1 polling again after reset", ser_ready, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule